// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block watches the receive side of a twisted-pair link for signs that the two wires of the pair have been swapped. The pulse qualifier in front of it reports each link pulse and each end-of-packet marker as a one-cycle strobe, together with a bit telling whether that event arrived with inverted sign. If enough inverted events arrive in an unbroken run, the block latches a reversed-polarity state. Link pulses and end-of-packet markers are counted separately, each against its own threshold.

While the reversed state is latched, every received data bit is inverted before it is passed on, so reception carries on correctly without any change to the wiring. The state also drives a polarity indicator output. It stays set until reset or until the link is reported lost. After that, detection starts again from empty counters. Inversion is applied only at bit boundaries: the corrected output changes only on a bit strobe, so a bit is never partly inverted.

Top module: `rx_pol_fix`

## Requirements
- R1: After reset, `pol_reversed`, `pol_led` (default active-high) and `rx_bit_out` are all 0.
- R2: Seven consecutive link-pulse strobes with `lp_inv`=1 set `pol_reversed` in the cycle after the seventh strobe. Six such strobes do not set it.
- R3: Three consecutive end-of-packet strobes with `eop_inv`=1 set `pol_reversed` in the cycle after the third strobe. Two such strobes do not set it.
- R4: A link-pulse strobe with `lp_inv`=0 restarts the inverted link-pulse run from zero.
- R5: An end-of-packet strobe with `eop_inv`=0 restarts the inverted end-of-packet run from zero.
- R6: The two runs are independent. Link-pulse strobes of either sign neither advance nor restart the end-of-packet run, and end-of-packet strobes likewise leave the link-pulse run alone. Whichever run reaches its threshold first sets the state.
- R7: Once set, `pol_reversed` stays at 1 while `link_lost`=0, whatever strobes arrive.
- R8: `link_lost`=1 clears `pol_reversed` in the next cycle and empties both runs. Strobes in that same cycle are not counted.
- R9: On each cycle with `rx_bit_valid`=1, `rx_bit_out` takes `rx_bit_in` XOR the value `pol_reversed` had before that clock edge, and holds between strobes. A bit strobed in the same cycle that the threshold is reached is therefore still passed through uninverted.
- R10: `pol_led` equals `pol_reversed` when `LED_ACTIVE_LOW`=0, and its complement when `LED_ACTIVE_LOW`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_lost | input | 1 | Link integrity lost; clears the latched state and both runs |
| lp_seen | input | 1 | One-cycle strobe: link pulse received |
| lp_inv | input | 1 | Sign of that link pulse, 1 = inverted |
| eop_seen | input | 1 | One-cycle strobe: end-of-packet marker received |
| eop_inv | input | 1 | Sign of that marker, 1 = inverted |
| rx_bit_valid | input | 1 | Bit-boundary strobe for `rx_bit_in` |
| rx_bit_in | input | 1 | Raw received data bit |
| rx_bit_out | output | 1 | Polarity-corrected data bit, registered |
| pol_reversed | output | 1 | Latched reversed-polarity status |
| pol_led | output | 1 | Polarity indicator drive |

## Verification
The bench targets the off-by-one edges of both thresholds (six against seven link pulses, two against three markers). An early or late count would show up as the status rising one strobe too soon or too late. It breaks runs with one correctly signed event and mixes the two event kinds. A design that restarted the wrong run, or shared one counter, would then set or miss the latch. It strobes a data bit in the exact cycle the threshold is reached to catch inversion that starts too early. It also asserts loss of link together with inverted strobes to catch a latch or run that is not fully emptied.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

  // Next value of an inverted-event run: restart on a correctly signed
  // event, advance on an inverted one, saturate at the threshold.
  function automatic int unsigned run_step(int unsigned cur, logic evt,
                                           logic inv, int unsigned thr);
    if (!evt) return cur;
    if (!inv) return 0;
    if (cur >= thr) return thr;
    return cur + 1;
  endfunction

  function automatic int unsigned run_width(int unsigned thr);
    return (thr < 2) ? 1 : $clog2(thr + 1);
  endfunction

endpackage

// File: rtl/pol_run_counter.sv
module pol_run_counter
  import rxpol_pkg::*;
#(
  parameter int unsigned THRESH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  input  logic evt_inv,
  output logic hit
);
  localparam int unsigned CW = run_width(THRESH);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (clr) run_q <= '0;
    else run_q <= CW'(run_step({{(32-CW){1'b0}}, run_q}, evt, evt_inv, THRESH));
  end

  assign hit = evt & evt_inv & ~clr & (run_q == LAST);

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(THRESH));

  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !evt_inv) |=> (run_q == '0));

endmodule

// File: rtl/pol_state_latch.sv
module pol_state_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic link_lost,
  input  logic lp_hit,
  input  logic eop_hit,
  output logic pol_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pol_q <= 1'b0;
    else if (link_lost) pol_q <= 1'b0;
    else if (lp_hit || eop_hit) pol_q <= 1'b1;
  end

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q && !link_lost) |=> pol_q);

  assert_link_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |=> !pol_q);

  assert_set_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pol_q && !link_lost && !lp_hit && !eop_hit) |=> !pol_q);

endmodule

// File: rtl/pol_bit_fix.sv
module pol_bit_fix (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic invert,
  output logic bit_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) bit_out <= 1'b0;
    else if (bit_valid) bit_out <= bit_in ^ invert;
  end

  assert_bit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(bit_out));

endmodule

// File: rtl/rx_pol_fix.sv
module rx_pol_fix #(
  parameter int unsigned LP_THRESH      = 7,
  parameter int unsigned EOP_THRESH     = 3,
  parameter bit          LED_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_lost,
  input  logic lp_seen,
  input  logic lp_inv,
  input  logic eop_seen,
  input  logic eop_inv,
  input  logic rx_bit_valid,
  input  logic rx_bit_in,
  output logic rx_bit_out,
  output logic pol_reversed,
  output logic pol_led
);
  // Named internal events for the assertions
  logic lp_hit;
  logic eop_hit;

  pol_run_counter #(.THRESH(LP_THRESH)) u_lp_run (
    .clk(clk), .rst_n(rst_n), .clr(link_lost),
    .evt(lp_seen), .evt_inv(lp_inv), .hit(lp_hit)
  );

  pol_run_counter #(.THRESH(EOP_THRESH)) u_eop_run (
    .clk(clk), .rst_n(rst_n), .clr(link_lost),
    .evt(eop_seen), .evt_inv(eop_inv), .hit(eop_hit)
  );

  pol_state_latch u_latch (
    .clk(clk), .rst_n(rst_n), .link_lost(link_lost),
    .lp_hit(lp_hit), .eop_hit(eop_hit), .pol_q(pol_reversed)
  );

  pol_bit_fix u_fix (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_bit_valid),
    .bit_in(rx_bit_in), .invert(pol_reversed), .bit_out(rx_bit_out)
  );

  generate
    if (LED_ACTIVE_LOW) begin : g_led_low
      assign pol_led = ~pol_reversed;
    end else begin : g_led_high
      assign pol_led = pol_reversed;
    end
  endgenerate

  assert_data_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_valid |=> (rx_bit_out == ($past(rx_bit_in) ^ $past(pol_reversed))));

endmodule

// File: tb/rx_pol_fix_tb.sv
module rx_pol_fix_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_lost = 1'b0, lp_seen = 1'b0, lp_inv = 1'b0;
  logic eop_seen = 1'b0, eop_inv = 1'b0, rx_bit_valid = 1'b0, rx_bit_in = 1'b0;
  logic rx_bit_out, pol_reversed, pol_led;

  int checks = 0;
  int failures = 0;
  int unsigned m_lp = 0, m_eop = 0;
  logic m_pol = 1'b0, m_out = 1'b0;

  always #10 clk = ~clk;

  rx_pol_fix u_dut (
    .clk(clk), .rst_n(rst_n), .link_lost(link_lost),
    .lp_seen(lp_seen), .lp_inv(lp_inv), .eop_seen(eop_seen), .eop_inv(eop_inv),
    .rx_bit_valid(rx_bit_valid), .rx_bit_in(rx_bit_in),
    .rx_bit_out(rx_bit_out), .pol_reversed(pol_reversed), .pol_led(pol_led)
  );

  // Expected run value after one strobe, as the requirements describe it
  function automatic int unsigned exp_run(int unsigned cur, logic s, logic inv, int unsigned thr);
    int unsigned r;
    r = cur;
    if (s) r = inv ? ((cur + 1 > thr) ? thr : cur + 1) : 0;
    return r;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge
  task automatic cyc(logic ll, logic ls, logic li, logic es, logic ei, logic bv, logic bi);
    logic old_pol;
    link_lost = ll; lp_seen = ls; lp_inv = li; eop_seen = es; eop_inv = ei;
    rx_bit_valid = bv; rx_bit_in = bi;
    @(posedge clk);
    old_pol = m_pol;
    if (rst_n) begin
      if (ll) begin
        m_lp = 0; m_eop = 0; m_pol = 1'b0;
      end else begin
        if ((ls && li && m_lp == 6) || (es && ei && m_eop == 2)) m_pol = 1'b1;
        m_lp = exp_run(m_lp, ls, li, 7);
        m_eop = exp_run(m_eop, es, ei, 3);
      end
      if (bv) m_out = bi ^ old_pol;
    end
    @(negedge clk);
  endtask

  task automatic check_model(string tag);
    check({tag, " status"}, pol_reversed, m_pol);
    check({tag, " led R10"}, pol_led, m_pol);
    check({tag, " data"}, rx_bit_out, m_out);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    m_lp = 0; m_eop = 0; m_pol = 1'b0; m_out = 1'b0;
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 status after reset", pol_reversed, 1'b0);
    check("R1 led after reset", pol_led, 1'b0);
    check("R1 data after reset", rx_bit_out, 1'b0);

    // R2: six inverted pulses are not enough, the seventh sets the state
    for (int i = 0; i < 6; i++) begin cyc(0, 1, 1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0); end
    check("R2 six inverted pulses", pol_reversed, 1'b0);
    cyc(0, 1, 1, 0, 0, 1, 1);   // seventh pulse with a bit strobe in the same cycle
    check("R2 seventh inverted pulse", pol_reversed, 1'b1);
    check("R9 bit in threshold cycle uninverted", rx_bit_out, 1'b1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    check("R9 output held between strobes", rx_bit_out, 1'b1);
    cyc(0, 0, 0, 0, 0, 1, 1);
    check("R9 first bit after latch inverted", rx_bit_out, 1'b0);
    check("R10 led on", pol_led, 1'b1);

    // R7: correctly signed events do not clear the state
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, 1, 0, 0, 0);
    check("R7 latch holds", pol_reversed, 1'b1);

    // R8: loss of link clears, and strobes in that cycle are not counted
    cyc(1, 1, 1, 1, 1, 0, 0);
    check("R8 link loss clears", pol_reversed, 1'b0);
    cyc(0, 1, 1, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    check("R8 runs emptied", pol_reversed, 1'b0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    check("R3 third inverted marker", pol_reversed, 1'b1);

    // R3: two inverted markers are not enough
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    check("R3 two inverted markers", pol_reversed, 1'b0);

    // R5: a correct marker restarts the marker run
    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    check("R5 correct marker restarts run", pol_reversed, 1'b0);

    // R6: link pulses of either sign leave the marker run alone
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    check("R6 marker run kept across pulses", pol_reversed, 1'b1);

    // R4: a correct pulse restarts the pulse run
    cyc(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 0, 0, 0);
    check("R4 correct pulse restarts run", pol_reversed, 1'b0);
    // R6: a correct marker does not restart the pulse run
    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    check("R6 pulse run kept across markers", pol_reversed, 1'b1);

    // R9: data passes unchanged when not reversed
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 1);
    check("R9 uninverted data", rx_bit_out, 1'b1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R9 uninverted zero", rx_bit_out, 1'b0);

    // Random mix against the bench model
    void'($urandom(32'h5eed_1234));
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic ll, ls, li, es, ei, bv, bi;
      ll = ($urandom % 97) == 0;
      ls = ($urandom % 3) == 0;
      li = ($urandom % 8) != 0;
      es = ($urandom % 5) == 0;
      ei = ($urandom % 4) != 0;
      bv = ($urandom % 2) == 0;
      bi = 1'($urandom);
      cyc(ll, ls, li, es, ei, bv, bi);
      check_model("R2 R3 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule